// File: doc/BRIEF.md
# Raster Scan Timing Generator

The block turns a programmable set of display-timing numbers into a raster scan: horizontal and vertical sync pulses, an 8-bit colour byte per pixel clock, and a read request to a frame-buffer memory for each visible pixel. Each axis is given as four counts: visible length, sync start, sync end and total. Each sync pulse has its own polarity. One frame-buffer row can be shown on several consecutive scan lines, so a shorter buffer fills the full visible height. Rows in the buffer sit at addresses padded to a multiple of 16 bytes, with room for one extra byte per row.

Four one-cycle strobes mark fixed places in the scan so that other logic can start work in step with the beam: end of display line, start of display line, end of image and start of image. A level output shows when the beam is in vertical blanking, which is the safe time to draw. The timing inputs are captured when the scan starts and again at each frame boundary, so a change made mid-frame takes effect cleanly on the next frame.

Top module: `scan_timing_top`

## Requirements
- R1: While running, at beam column x the horizontal sync output is at its active level when h_sync_start <= x < h_sync_end, and at the opposite level otherwise. The active level is high when h_sync_pol is 1 and low when it is 0.
- R2: Vertical sync follows the same rule on the line number y using v_sync_start, v_sync_end and v_sync_pol.
- R3: For a visible pixel (x < h_active and y < v_active) the colour output carries the byte read from frame-buffer address row*stride + x, unchanged, with red in bits 7:5, green in bits 4:2 and blue in bits 1:0. All outputs are aligned: beam position (0,0) reaches the outputs on the third rising clock edge that samples enable high, and the read data is taken one cycle after fb_rd.
- R4: At column x = h_active of every visible line the colour output is 0 (one forced black pixel), and it is 0 at every position outside the visible area; fb_rd is low there.
- R5: The row stride in bytes is (h_active + 16) with its four low bits cleared, so every row starts on a 16-byte boundary and has room for one pixel beyond h_active.
- R6: With line_repeat = N (N >= 1), frame-buffer row r is shown on scan lines r*N to r*N + N - 1.
- R7: ev_line_end pulses for one cycle on every line at x = h_sync_start when h_sync_pol is 1, and at x = h_sync_end when it is 0.
- R8: ev_line_start pulses for one cycle on every line, blank lines included, at x = h_sync_end.
- R9: ev_image_end pulses for one cycle at x = h_active on line y = v_active - 1, the position just after the last visible pixel.
- R10: ev_image_start pulses for one cycle at x = 0 on line y = v_total - 1, the line just above the first visible line.
- R11: offscreen is 1 while y >= v_active and while the scan is stopped, and 0 on lines y < v_active.
- R12: The timing inputs are captured when the scan starts and at the end of each frame; a change made mid-frame has no effect until the next frame.
- R13: While stopped (and from reset), after the pipeline drains the syncs sit at their inactive levels, the colour output is 0, and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the scan; low stops it and returns the beam to (0,0) |
| h_active | input | 12 | Visible pixels per line |
| h_sync_start | input | 12 | Column where horizontal sync begins |
| h_sync_end | input | 12 | Column where horizontal sync ends (exclusive) |
| h_total | input | 12 | Pixel clocks per line |
| v_active | input | 12 | Visible lines per frame |
| v_sync_start | input | 12 | Line where vertical sync begins |
| v_sync_end | input | 12 | Line where vertical sync ends (exclusive) |
| v_total | input | 12 | Lines per frame |
| h_sync_pol | input | 1 | 1 = horizontal sync active high |
| v_sync_pol | input | 1 | 1 = vertical sync active high |
| line_repeat | input | 4 | Scan lines per frame-buffer row |
| fb_addr | output | 20 | Frame-buffer byte address |
| fb_rd | output | 1 | Read strobe, data expected next cycle |
| fb_data | input | 8 | Read data (colour byte) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| rgb | output | 8 | Colour byte |
| ev_line_end | output | 1 | End-of-display-line strobe |
| ev_line_start | output | 1 | Start-of-display-line strobe |
| ev_image_end | output | 1 | End-of-image strobe |
| ev_image_start | output | 1 | Start-of-image strobe |
| offscreen | output | 1 | Beam in vertical blanking or stopped |

## Verification
The assertions take the timing inputs as ordered: h_active < h_sync_start < h_sync_end <= h_total, the same ordering vertically with v_active < v_total, h_total of at least 2, and line_repeat non-zero. They also assume that fb_data is a pure function of the address given one cycle earlier. The stimulus uses only three timing sets that keep to this ordering. It changes inputs mid-frame only in the capture test. The memory model is a registered function of the address, so every expected colour can be computed from position, stride and repeat factor alone.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int CW = 12;   // coordinate width
    localparam int RW = 4;    // line-repeat field width

    typedef struct packed {
        logic [CW-1:0] h_act;
        logic [CW-1:0] h_ss;
        logic [CW-1:0] h_se;
        logic [CW-1:0] h_tot;
        logic [CW-1:0] v_act;
        logic [CW-1:0] v_ss;
        logic [CW-1:0] v_se;
        logic [CW-1:0] v_tot;
        logic          h_pos;
        logic          v_pos;
        logic [RW-1:0] rpt;
    } mode_t;

    typedef struct packed {
        logic hs_lvl;
        logic vs_lvl;
        logic vis;
        logic line_end;
        logic line_start;
        logic img_end;
        logic img_start;
        logic off;
    } flags_t;

    // Bytes between row starts: room for one trailing pixel, rounded to 16.
    function automatic logic [CW:0] row_stride(input logic [CW-1:0] act);
        return ({1'b0, act} + (CW+1)'(16)) & ~(CW+1)'(15);
    endfunction

    // Flag set seen while the scan is stopped.
    function automatic flags_t idle_flags(input logic hp, input logic vp);
        flags_t f;
        f = '0;
        f.hs_lvl = ~hp;
        f.vs_lvl = ~vp;
        f.off    = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/scan_beam.sv
module scan_beam
    import scan_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  mode_t         mode_in,
    output logic          run,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic          line_done,
    output logic          frame_done,
    output flags_t        flags,
    output logic [CW-1:0] cur_h_act,
    output logic [CW-1:0] cur_v_act,
    output logic [RW-1:0] cur_rpt,
    output logic          cur_h_pos,
    output logic          cur_v_pos
);
    mode_t mode;

    assign line_done  = (x == mode.h_tot - 1'b1);
    assign frame_done = line_done && (y == mode.v_tot - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            x    <= '0;
            y    <= '0;
            mode <= mode_in;
        end else if (!run) begin
            mode <= mode_in;          // capture while stopped
            x    <= '0;
            y    <= '0;
            run  <= enable;
        end else if (!enable) begin
            run <= 1'b0;
            x   <= '0;
            y   <= '0;
        end else if (line_done) begin
            x <= '0;
            if (frame_done) begin
                y    <= '0;
                mode <= mode_in;      // capture at frame boundary
            end else begin
                y <= y + 1'b1;
            end
        end else begin
            x <= x + 1'b1;
        end
    end

    always_comb begin
        flags = idle_flags(mode.h_pos, mode.v_pos);
        if (run) begin
            flags.hs_lvl     = (x >= mode.h_ss && x < mode.h_se) ? mode.h_pos : ~mode.h_pos;
            flags.vs_lvl     = (y >= mode.v_ss && y < mode.v_se) ? mode.v_pos : ~mode.v_pos;
            flags.vis        = (x < mode.h_act) && (y < mode.v_act);
            flags.line_end   = (x == (mode.h_pos ? mode.h_ss : mode.h_se));
            flags.line_start = (x == mode.h_se);
            flags.img_end    = (x == mode.h_act) && (y == mode.v_act - 1'b1);
            flags.img_start  = (x == '0) && (y == mode.v_tot - 1'b1);
            flags.off        = (y >= mode.v_act);
        end
    end

    assign cur_h_act = mode.h_act;
    assign cur_v_act = mode.v_act;
    assign cur_rpt   = mode.rpt;
    assign cur_h_pos = mode.h_pos;
    assign cur_v_pos = mode.v_pos;

    AST_X_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        run |-> (x < mode.h_tot)) else $error("column past line end"); // R1
    AST_Y_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run |-> (y < mode.v_tot)) else $error("line past frame end"); // R2

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CW-1:0]     x,
    input  logic [CW-1:0]     y,
    input  logic              line_done,
    input  logic              frame_done,
    input  logic [CW-1:0]     h_act,
    input  logic [CW-1:0]     v_act,
    input  logic [RW-1:0]     rpt,
    output logic [ADDR_W-1:0] fb_addr,
    output logic              fb_rd
);
    logic [ADDR_W-1:0] row_base;
    logic [RW-1:0]     rep;
    logic              last_rep;

    assign last_rep = (({1'b0, rep} + 1'b1) >= {1'b0, rpt});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            row_base <= '0;
            rep      <= '0;
        end else if (line_done) begin
            if (frame_done) begin
                row_base <= '0;
                rep      <= '0;
            end else if (last_rep) begin
                row_base <= row_base + ADDR_W'(row_stride(h_act));
                rep      <= '0;
            end else begin
                rep <= rep + 1'b1;
            end
        end
    end

    assign fb_rd   = run && (x < h_act) && (y < v_act);
    assign fb_addr = row_base + ADDR_W'(x);

    AST_ROW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (fb_rd && x == '0) |-> (fb_addr[3:0] == 4'h0)) else $error("row not 16-byte aligned"); // R5
    AST_REP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (run && rpt != '0) |-> (rep < rpt)) else $error("repeat count overran"); // R6

endmodule

// File: rtl/scan_pipe.sv
module scan_pipe
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flags_t     flags,
    input  logic       h_pos,
    input  logic       v_pos,
    input  logic [7:0] fb_data,
    output logic       hsync,
    output logic       vsync,
    output logic [7:0] rgb,
    output logic       ev_line_end,
    output logic       ev_line_start,
    output logic       ev_image_end,
    output logic       ev_image_start,
    output logic       offscreen
);
    flags_t f1;   // aligned with the read latency

    always_ff @(posedge clk) begin
        if (rst) begin
            f1             <= idle_flags(h_pos, v_pos);
            hsync          <= ~h_pos;
            vsync          <= ~v_pos;
            rgb            <= '0;
            ev_line_end    <= 1'b0;
            ev_line_start  <= 1'b0;
            ev_image_end   <= 1'b0;
            ev_image_start <= 1'b0;
            offscreen      <= 1'b1;
        end else begin
            f1             <= flags;
            hsync          <= f1.hs_lvl;
            vsync          <= f1.vs_lvl;
            rgb            <= f1.vis ? fb_data : 8'h00;
            ev_line_end    <= f1.line_end;
            ev_line_start  <= f1.line_start;
            ev_image_end   <= f1.img_end;
            ev_image_start <= f1.img_start;
            offscreen      <= f1.off;
        end
    end

    AST_DARK_OFFSCREEN: assert property (@(posedge clk) disable iff (rst)
        offscreen |-> (rgb == 8'h00)) else $error("colour during blanking"); // R4
    AST_IMG_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_image_end, ev_image_start})) else $error("image strobes overlap"); // R9
    AST_IMG_END_ONSCREEN: assert property (@(posedge clk) disable iff (rst)
        ev_image_end |-> !offscreen) else $error("image end outside last visible line"); // R9
    AST_IMG_START_OFFSCREEN: assert property (@(posedge clk) disable iff (rst)
        ev_image_start |-> offscreen) else $error("image start inside visible area"); // R10

endmodule

// File: rtl/scan_timing_top.sv
module scan_timing_top
    import scan_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [11:0]       h_active,
    input  logic [11:0]       h_sync_start,
    input  logic [11:0]       h_sync_end,
    input  logic [11:0]       h_total,
    input  logic [11:0]       v_active,
    input  logic [11:0]       v_sync_start,
    input  logic [11:0]       v_sync_end,
    input  logic [11:0]       v_total,
    input  logic              h_sync_pol,
    input  logic              v_sync_pol,
    input  logic [3:0]        line_repeat,
    output logic [ADDR_W-1:0] fb_addr,
    output logic              fb_rd,
    input  logic [7:0]        fb_data,
    output logic              hsync,
    output logic              vsync,
    output logic [7:0]        rgb,
    output logic              ev_line_end,
    output logic              ev_line_start,
    output logic              ev_image_end,
    output logic              ev_image_start,
    output logic              offscreen
);
    mode_t         mode_in;
    logic          run, line_done, frame_done;
    logic [CW-1:0] x, y, cur_h_act, cur_v_act;
    logic [RW-1:0] cur_rpt;
    logic          cur_h_pos, cur_v_pos;
    flags_t        flags;
    logic [1:0]    quiet_cnt;

    always_comb begin
        mode_in.h_act = h_active;
        mode_in.h_ss  = h_sync_start;
        mode_in.h_se  = h_sync_end;
        mode_in.h_tot = h_total;
        mode_in.v_act = v_active;
        mode_in.v_ss  = v_sync_start;
        mode_in.v_se  = v_sync_end;
        mode_in.v_tot = v_total;
        mode_in.h_pos = h_sync_pol;
        mode_in.v_pos = v_sync_pol;
        mode_in.rpt   = line_repeat;
    end

    scan_beam u_beam (
        .clk(clk), .rst(rst), .enable(enable), .mode_in(mode_in),
        .run(run), .x(x), .y(y), .line_done(line_done), .frame_done(frame_done),
        .flags(flags), .cur_h_act(cur_h_act), .cur_v_act(cur_v_act),
        .cur_rpt(cur_rpt), .cur_h_pos(cur_h_pos), .cur_v_pos(cur_v_pos)
    );

    scan_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst(rst), .run(run), .x(x), .y(y),
        .line_done(line_done), .frame_done(frame_done),
        .h_act(cur_h_act), .v_act(cur_v_act), .rpt(cur_rpt),
        .fb_addr(fb_addr), .fb_rd(fb_rd)
    );

    scan_pipe u_pipe (
        .clk(clk), .rst(rst), .flags(flags), .h_pos(cur_h_pos), .v_pos(cur_v_pos),
        .fb_data(fb_data), .hsync(hsync), .vsync(vsync), .rgb(rgb),
        .ev_line_end(ev_line_end), .ev_line_start(ev_line_start),
        .ev_image_end(ev_image_end), .ev_image_start(ev_image_start),
        .offscreen(offscreen)
    );

    // Cycles since enable was last seen high, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (rst || enable) quiet_cnt <= 2'd0;
        else if (quiet_cnt != 2'd3) quiet_cnt <= quiet_cnt + 2'd1;
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (quiet_cnt == 2'd3) |-> (rgb == 8'h00 && !ev_line_end && !ev_line_start &&
                                 !ev_image_end && !ev_image_start && offscreen))
        else $error("activity while stopped"); // R13

endmodule

// File: tb/scan_timing_top_tb.sv
`timescale 1ns/1ps
module scan_timing_top_tb;

    typedef struct {
        int ha, hss, hse, ht, va, vss, vse, vt, hp, vp, rpt;
    } bmode_t;

    typedef struct {
        bit hs, vs, le, ls, ie, is, off, vis;
        logic [7:0] rgb;
    } item_t;

    logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
    logic [11:0] h_active, h_sync_start, h_sync_end, h_total;
    logic [11:0] v_active, v_sync_start, v_sync_end, v_total;
    logic h_sync_pol, v_sync_pol;
    logic [3:0] line_repeat;
    logic [19:0] fb_addr;
    logic fb_rd;
    logic [7:0] fb_data = 8'h00;
    logic hsync, vsync, ev_line_end, ev_line_start, ev_image_end, ev_image_start, offscreen;
    logic [7:0] rgb;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    item_t q[$];
    string q_tag[$];
    event ev_start;
    bmode_t mA, mB, mC;

    always #5 clk = ~clk;

    scan_timing_top u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .h_active(h_active), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end), .h_total(h_total),
        .v_active(v_active), .v_sync_start(v_sync_start), .v_sync_end(v_sync_end), .v_total(v_total),
        .h_sync_pol(h_sync_pol), .v_sync_pol(v_sync_pol), .line_repeat(line_repeat),
        .fb_addr(fb_addr), .fb_rd(fb_rd), .fb_data(fb_data),
        .hsync(hsync), .vsync(vsync), .rgb(rgb),
        .ev_line_end(ev_line_end), .ev_line_start(ev_line_start),
        .ev_image_end(ev_image_end), .ev_image_start(ev_image_start),
        .offscreen(offscreen)
    );

    function automatic logic [7:0] pix(input int a);
        return {a[6:0], 1'b1};
    endfunction

    // Frame-buffer model: one cycle of read latency.
    always @(posedge clk) if (fb_rd) fb_data <= pix(int'(fb_addr));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input bmode_t m);
        h_active = 12'(m.ha); h_sync_start = 12'(m.hss); h_sync_end = 12'(m.hse); h_total = 12'(m.ht);
        v_active = 12'(m.va); v_sync_start = 12'(m.vss); v_sync_end = 12'(m.vse); v_total = 12'(m.vt);
        h_sync_pol = m.hp[0]; v_sync_pol = m.vp[0]; line_repeat = 4'(m.rpt);
    endtask

    // Driver side of the scoreboard: expected outputs for whole frames.
    task automatic expect_frames(input bmode_t m, input int n, input string tag);
        int stride;
        stride = (m.ha + 16) & ~15;
        for (int f = 0; f < n; f++)
            for (int yy = 0; yy < m.vt; yy++)
                for (int xx = 0; xx < m.ht; xx++) begin
                    item_t it;
                    it.vis = (xx < m.ha) && (yy < m.va);
                    it.rgb = it.vis ? pix((yy / m.rpt) * stride + xx) : 8'h00;
                    it.hs  = (xx >= m.hss && xx < m.hse) ? m.hp[0] : !m.hp[0];
                    it.vs  = (yy >= m.vss && yy < m.vse) ? m.vp[0] : !m.vp[0];
                    it.le  = (xx == (m.hp != 0 ? m.hss : m.hse));
                    it.ls  = (xx == m.hse);
                    it.ie  = (xx == m.ha) && (yy == m.va - 1);
                    it.is  = (xx == 0) && (yy == m.vt - 1);
                    it.off = (yy >= m.va);
                    q.push_back(it);
                    q_tag.push_back(tag);
                end
    endtask

    // Monitor side: pop and compare one item per cycle.
    initial begin
        forever begin
            @(ev_start);
            repeat (3) @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                string tg;
                it = q.pop_front();
                tg = q_tag.pop_front();
                chk(hsync == it.hs, "R1", "hsync", hsync, it.hs);
                chk(vsync == it.vs, "R2", "vsync", vsync, it.vs);
                chk(rgb == it.rgb, it.vis ? tg : "R4", "rgb", rgb, it.rgb);
                chk(ev_line_end == it.le, "R7", "ev_line_end", ev_line_end, it.le);
                chk(ev_line_start == it.ls, "R8", "ev_line_start", ev_line_start, it.ls);
                chk(ev_image_end == it.ie, "R9", "ev_image_end", ev_image_end, it.ie);
                chk(ev_image_start == it.is, "R10", "ev_image_start", ev_image_start, it.is);
                chk(offscreen == it.off, "R11", "offscreen", offscreen, it.off);
                if (q.size() > 0) @(negedge clk);
            end
        end
    end

    task automatic check_quiet(input bmode_t m, input string what);
        chk(hsync == !m.hp[0], "R13", {what, " hsync"}, hsync, !m.hp[0]);
        chk(vsync == !m.vp[0], "R13", {what, " vsync"}, vsync, !m.vp[0]);
        chk(rgb == 8'h00, "R13", {what, " rgb"}, rgb, 0);
        chk({ev_line_end, ev_line_start, ev_image_end, ev_image_start} == 4'b0, "R13",
            {what, " strobes"}, {ev_line_end, ev_line_start, ev_image_end, ev_image_start}, 0);
        chk(offscreen == 1'b1, "R11", {what, " offscreen"}, offscreen, 1);
    endtask

    task automatic start_scan(input bmode_t m);
        @(negedge clk);
        set_mode(m);
        enable = 1'b1;
        -> ev_start;
    endtask

    task automatic stop_scan(input bmode_t m);
        wait (q.size() == 0);
        @(negedge clk);
        enable = 1'b0;
        repeat (5) @(negedge clk);
        check_quiet(m, "stopped");
    endtask

    initial begin
        mA = '{ha:8,  hss:10, hse:12, ht:14, va:4, vss:5, vse:6, vt:8, hp:0, vp:0, rpt:2};
        mB = '{ha:15, hss:16, hse:18, ht:20, va:3, vss:4, vse:5, vt:6, hp:1, vp:1, rpt:1};
        mC = '{ha:16, hss:17, hse:19, ht:21, va:6, vss:7, vse:8, vt:9, hp:1, vp:0, rpt:3};
        set_mode(mA);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_quiet(mA, "reset");                     // R13 reset state

        // R3/R6: negative syncs, each row shown twice, stride 16
        expect_frames(mA, 2, "R3");
        start_scan(mA);
        stop_scan(mA);

        // R5/R7: positive syncs, h_active 15 keeps stride 16
        expect_frames(mB, 2, "R5");
        start_scan(mB);
        stop_scan(mB);

        // R6/R5: stride 32, rows shown three times; R12: mid-frame write waits
        expect_frames(mC, 1, "R6");
        expect_frames(mA, 1, "R12");
        start_scan(mC);
        repeat (30) @(negedge clk);
        set_mode(mA);
        stop_scan(mA);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule